// File: doc/BRIEF.md
# Byte-Wide EEPROM Write-Page Controller

This block is the control and timing logic of a byte-wide parallel EEPROM, built around a small array of synthesizable memory. A host drives a 17-bit address, an 8-bit data bus and three active-low strobes: chip select, output enable and write enable. There is also an active-high-to-run protect input, `prot_n`. Reads return the stored byte. Each write strobe is captured into a 128-byte page buffer. Once loading stops, a self-timed program cycle copies the buffered bytes into the array.

While a load or program cycle is in progress, the block reports busy in two ways. The `busy_pull` flag models an open-drain pull-low. A read returns a polling byte whose bit 7 is the complement of the last written bit 7. Pulling `prot_n` low blocks writes and abandons any load or program cycle that is in progress.

The controller has three states:

- `ST_IDLE`: no write is pending.
- `ST_LOAD`: bytes are being collected into the page buffer.
- `ST_PROG`: the buffer is being committed to the array.

The transitions between them are:

- `ST_IDLE` to `ST_LOAD` on the first accepted strobe.
- `ST_LOAD` to `ST_LOAD` on a strobe to the same page. This restarts the load window.
- `ST_LOAD` to `ST_PROG` when the load window expires, or on a strobe to a different page.
- `ST_PROG` to `ST_IDLE` when the program count ends.
- `ST_LOAD` or `ST_PROG` to `ST_IDLE` when `prot_n` is low.

The array has `MEM_DEPTH` bytes and is indexed by the low address bits. Higher pages alias onto it. It comes out of system reset holding 8'hFF.

Top module: `eep_page_ctrl`

## Requirements
- R1: Read. When idle with `sel_n`=0, `rd_n`=0, `wr_n`=1 and `prot_n`=1, `dout_en`=1 and `dout` equals the byte stored at the address, with no added latency. After system reset every byte reads 8'hFF.
- R2: Standby. When `sel_n`=1, `dout_en`=0 and `busy_pull`=0.
- R3: Write strobe. A strobe is the first clock cycle of `sel_n`=0, `wr_n`=0, `rd_n`=1, `prot_n`=1. It captures the address and data, and the byte is readable after the program cycle.
- R4: Page load. All strobes whose address bits 16:7 match are programmed together in one cycle, and a later strobe to the same slot overrides an earlier one. Bytes of the page that were not written keep their contents.
- R5: The load closes `LOAD_WIN` cycles after the last accepted strobe.
- R6: A strobe to a different page while loading closes the load at once and is discarded.
- R7: Polling. While busy, a read gives `dout[7]` equal to the complement of the last written bit 7, and `dout[6:0]`=0.
- R8: `busy_pull`=1 while in `ST_LOAD` or `ST_PROG` with `sel_n`=0, and it is 0 once the cycle ends.
- R9: Strobes during `ST_PROG` are ignored. They change neither the array nor the page buffer.
- R10: With `prot_n`=0 no strobe is accepted. `prot_n`=0 during a load discards the load and returns to idle.
- R11: Write inhibit. `wr_n`=0 together with `rd_n`=0 neither writes nor drives the bus.
- R12: After the load closes, `busy_pull` stays asserted for `PROG_CYC` cycles, within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| prot_n | input | 1 | Program reset / write protect, active low |
| addr | input | 17 | Byte address; bits 16:7 page, bits 6:0 slot |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling byte |
| dout_en | output | 1 | Data bus drive enable |
| busy_pull | output | 1 | Ready/busy pull-low |

## Verification
Random page loads of one to eight bytes, with random slots and data, are each read back over the whole page. This separates the committed bytes, the last-write-wins slots and the untouched neighbours. The directed cases cover the following, each against an idle read-back:

- polling with both values of bit 7;
- busy duration measured from the last strobe;
- a second-page strobe that closes the load;
- a strobe issued during programming;
- a protect pulse during loading;
- writes made with protect low;
- writes made with output enable low.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eep_state_t;
    localparam int PAGE_BYTES = 128;
    localparam int SLOT_W     = 7;
endpackage

// File: rtl/eep_wr_strobe.sv
module eep_wr_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic prot_n,
    output logic strobe
);
    logic wr_cond, prev_q;

    assign wr_cond = !sel_n && !wr_n && rd_n && prot_n;
    assign strobe  = wr_cond && !prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= wr_cond;
    end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int DEPTH = 128,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_vld,
    output logic [7:0]    rd_data
);
    logic [7:0]       data_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && wr_idx == IW'(i)) vld_q[i] <= 1'b1;
                else if (clr)                  vld_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_idx] <= wr_data;
    end

    assign rd_vld  = vld_q[rd_idx];
    assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int MEM_DEPTH = 1024,
    parameter int LOAD_WIN  = 16,
    parameter int PROG_CYC  = 200,
    localparam int MEM_AW   = $clog2(MEM_DEPTH),
    localparam int TAG_W    = ADDR_W - SLOT_W,
    localparam int TW       = $clog2(LOAD_WIN + 1),
    localparam int CW       = $clog2(PROG_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              prot_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy_pull
);
    eep_state_t state_q, state_d;
    logic [TW-1:0]     timer_q;
    logic [CW-1:0]     cnt_q;
    logic [TAG_W-1:0]  tag_q;
    logic              last7_q;
    logic              strobe, same_page, accept, buf_clr, arr_we, busy;
    logic              buf_vld;
    logic [7:0]        buf_data, arr_rd;
    logic [SLOT_W-1:0] slot;

    eep_wr_strobe strobe_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n),
        .wr_n(wr_n), .prot_n(prot_n), .strobe(strobe)
    );

    assign same_page = addr[ADDR_W-1:SLOT_W] == tag_q;
    assign slot      = SLOT_W'(cnt_q);

    // next-state process
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        buf_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: if (strobe) begin
                state_d = ST_LOAD;
                accept  = 1'b1;
                buf_clr = 1'b1;
            end
            ST_LOAD: begin
                if (!prot_n)                          state_d = ST_IDLE;
                else if (strobe && same_page)         accept  = 1'b1;
                else if (strobe)                      state_d = ST_PROG;
                else if (timer_q == TW'(LOAD_WIN - 1)) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (!prot_n)                          state_d = ST_IDLE;
                else if (cnt_q == CW'(PROG_CYC - 1))  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
            cnt_q   <= '0;
            tag_q   <= '0;
            last7_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                timer_q <= '0;
                tag_q   <= addr[ADDR_W-1:SLOT_W];
                last7_q <= din[7];
            end else if (state_q == ST_LOAD) begin
                timer_q <= timer_q + 1'b1;
            end
            if (state_q == ST_PROG) cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= '0;
        end
    end

    eep_page_buf #(.DEPTH(PAGE_BYTES)) buf_i (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(accept),
        .wr_idx(addr[SLOT_W-1:0]), .wr_data(din),
        .rd_idx(slot), .rd_vld(buf_vld), .rd_data(buf_data)
    );

    assign arr_we = state_q == ST_PROG && prot_n &&
                    cnt_q < CW'(PAGE_BYTES) && buf_vld;

    logic [ADDR_W-1:0] waddr_full;
    assign waddr_full = {tag_q, slot};

    eep_array #(.DEPTH(MEM_DEPTH)) arr_i (
        .clk(clk), .rst_n(rst_n), .we(arr_we),
        .waddr(waddr_full[MEM_AW-1:0]), .wdata(buf_data),
        .raddr(addr[MEM_AW-1:0]), .rdata(arr_rd)
    );

    // output process
    always_comb begin
        busy      = state_q != ST_IDLE;
        dout_en   = !sel_n && !rd_n && wr_n && prot_n;
        dout      = busy ? {!last7_q, 7'b0} : arr_rd;
        busy_pull = busy && !sel_n;
    end

    // R9
    prog_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PROG |-> !accept);
    // R2
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !dout_en && !busy_pull);
    // R10
    prot_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_n && state_q != ST_IDLE) |=> state_q == ST_IDLE);
    // R5
    load_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOAD |-> timer_q < TW'(LOAD_WIN));
    // R8
    prog_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && cnt_q == CW'(PROG_CYC - 1)) |=> state_q == ST_IDLE);
    // R3
    array_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> state_q == ST_PROG && prot_n);
endmodule

// File: tb/eep_page_ctrl_tb_top.sv
module eep_page_ctrl_tb_top;
    localparam int LOAD_WIN = 16;
    localparam int PROG_CYC = 200;
    localparam int DEPTH    = 1024;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, prot_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, busy_pull;
    int checks = 0, errors = 0;
    logic [7:0] model [DEPTH];

    always #4 clk = !clk;

    eep_page_ctrl #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC), .MEM_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
        .prot_n(prot_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .busy_pull(busy_pull)
    );

    function automatic logic [7:0] poll_val(input logic [7:0] d);
        return {!d[7], 7'b0};
    endfunction

    function automatic int midx(input logic [16:0] a);
        return int'(a[9:0]);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [16:0] a, input logic [7:0] d, input logic oe);
        @(negedge clk);
        addr = a; din = d; sel_n = 1'b0; rd_n = oe; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; sel_n = 1'b1;
    endtask

    task automatic rd_byte(input logic [16:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
        #1; d = dout; en = dout_en;
        rd_n = 1'b1; sel_n = 1'b1;
    endtask

    task automatic wait_ready(output int cyc);
        cyc = 0;
        @(negedge clk);
        sel_n = 1'b0;
        #1;
        while (busy_pull && cyc < 2000) begin
            @(negedge clk); #1; cyc++;
        end
        sel_n = 1'b1;
    endtask

    task automatic idle_busy(output logic b);
        @(negedge clk);
        sel_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        #1; b = busy_pull;
        sel_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] d;
        logic en, b;
        int cyc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 standby after reset
        @(negedge clk); #1;
        check("R2 standby dout_en", dout_en, 0);
        check("R2 standby busy", busy_pull, 0);
        // R1 reset contents
        rd_byte(17'h00123, d, en);
        check("R1 reset read", d, 8'hFF);
        check("R1 drive", en, 1);

        // R7 polling and R12 busy length
        wr_byte(17'h00005, 8'h3C, 1'b1);
        rd_byte(17'h00005, d, en);
        check("R7 poll bit7 low data", d, poll_val(8'h3C));
        wait_ready(cyc);
        check("R12 busy length in range",
              (cyc >= LOAD_WIN + PROG_CYC - 4 && cyc <= LOAD_WIN + PROG_CYC + 2), 1);
        check("R8 busy released", busy_pull, 0);
        model[5] = 8'h3C;
        rd_byte(17'h00005, d, en);
        check("R3 single byte", d, 8'h3C);
        wr_byte(17'h00006, 8'hA1, 1'b1);
        rd_byte(17'h00006, d, en);
        check("R7 poll bit7 high data", d, poll_val(8'hA1));
        @(negedge clk); sel_n = 1'b0; #1;
        check("R8 busy pulled", busy_pull, 1);
        sel_n = 1'b1;
        wait_ready(cyc);
        model[6] = 8'hA1;

        // R6 different page closes load, strobe discarded
        wr_byte(17'h00081, 8'h11, 1'b1);
        wr_byte(17'h00102, 8'h22, 1'b1);
        wait_ready(cyc);
        check("R6 early close busy length", (cyc <= PROG_CYC + 4), 1);
        model[midx(17'h00081)] = 8'h11;
        rd_byte(17'h00081, d, en);
        check("R6 first page written", d, 8'h11);
        rd_byte(17'h00102, d, en);
        check("R6 other page discarded", d, model[midx(17'h00102)]);

        // R9 strobe during programming ignored
        wr_byte(17'h00200, 8'h55, 1'b1);
        repeat (LOAD_WIN + 6) @(negedge clk);
        wr_byte(17'h00201, 8'h66, 1'b1);
        wr_byte(17'h00380, 8'h77, 1'b1);
        wait_ready(cyc);
        model[midx(17'h00200)] = 8'h55;
        rd_byte(17'h00201, d, en);
        check("R9 same page ignored", d, model[midx(17'h00201)]);
        rd_byte(17'h00380, d, en);
        check("R9 other page ignored", d, model[midx(17'h00380)]);
        rd_byte(17'h00200, d, en);
        check("R9 original byte kept", d, 8'h55);

        // R10 protect during load discards
        wr_byte(17'h00010, 8'h99, 1'b1);
        @(negedge clk); prot_n = 1'b0;
        @(negedge clk); @(negedge clk); prot_n = 1'b1;
        idle_busy(b);
        check("R10 abort not busy", b, 0);
        rd_byte(17'h00010, d, en);
        check("R10 aborted byte", d, model[16]);
        // R10 write with protect low
        @(negedge clk); prot_n = 1'b0;
        wr_byte(17'h00011, 8'h44, 1'b1);
        @(negedge clk); prot_n = 1'b1;
        idle_busy(b);
        check("R10 protected not busy", b, 0);
        rd_byte(17'h00011, d, en);
        check("R10 protected byte", d, model[17]);

        // R11 write inhibit with output enable low
        @(negedge clk);
        addr = 17'h00012; din = 8'h01; sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        #1;
        check("R11 no drive", dout_en, 0);
        @(negedge clk); wr_n = 1'b1; rd_n = 1'b1; sel_n = 1'b1;
        idle_busy(b);
        check("R11 not busy", b, 0);
        rd_byte(17'h00012, d, en);
        check("R11 byte kept", d, model[18]);

        // R4 R5 random page loads
        for (int r = 0; r < 12; r++) begin
            logic [16:0] base;
            int n;
            base = {10'($urandom), 7'b0};
            n = 1 + int'($urandom % 8);
            for (int k = 0; k < n; k++) begin
                logic [6:0] s;
                logic [7:0] v;
                s = (k == n - 1 && n > 2) ? 7'd1 : 7'($urandom);
                v = 8'($urandom);
                wr_byte(base | 17'(s), v, 1'b1);
                model[midx(base | 17'(s))] = v;
            end
            wait_ready(cyc);
            check("R5 load closed and programmed", (cyc >= PROG_CYC && cyc < 2000), 1);
            for (int s2 = 0; s2 < 128; s2++) begin
                rd_byte(base | 17'(s2), d, en);
                check("R4 page readback", d, model[midx(base | 17'(s2))]);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule